// File: doc/BRIEF.md
# Dual Masked Calendar Alarm Comparator

This block keeps two independent alarm settings and compares each of them with the running BCD time and calendar. The time arrives on input buses from a separate timekeeping counter. A single-cycle seconds strobe marks when that time has advanced. Each alarm has six compared fields: second, minute, hour, date, month and day of week. Each field has its own enable bit, so a single comparator can describe a yearly, weekly, daily or hourly alarm. An alarm with every enable cleared never fires.

A matching alarm sets a sticky flag. Software can poll the flag over a byte-wide register bus. It can also let the flag pull an active-low interrupt line, gated per alarm. Flags are cleared by writing 0 to their bit. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `cal_alarm_pair`

## Requirements
- R1: After reset every alarm register, the flag register and the interrupt-enable register read 0x00, and `irq_n` is 1. Alarm n (n = 0 or 1) sits at base 8n with slot offsets: second +0, minute +1, hour +2, date +3, month +4, day of week +6.
- R2: In each alarm field register, bit 7 is the field enable and the low bits hold the BCD value: 7 bits for second and minute, 6 for hour and date, 5 for month, 3 for day of week. Written 1s in the remaining reserved bits are dropped and those bits read 0, so 0xFF written to month reads 0x9F, to day of week 0x87, to hour and date 0xBF, and to second 0xFF.
- R3: Matching is evaluated only in a cycle with `tick` high. If every enabled field of alarm n equals the live value (hour bit 5, the tens or PM bit, compared like any other bit), bit n of the flag register is 1 from the following cycle. A matching time without `tick` sets nothing.
- R4: An alarm whose six enable bits are all 0 never sets its flag, whatever its values.
- R5: Offset +5 of each alarm reads back the live year and ignores writes; the year never takes part in matching. Offset +7 reads 0x00 and ignores writes.
- R6: The flag register at 0x10 holds alarm n's flag in bit n, and its bits 7:2 read 0. A flag stays set until a write to 0x10 carries 0 in its bit; a 1 in the written bit leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R7: The interrupt-enable register at 0x11 holds the enable for alarm n in bit n, and its bits 7:2 read 0. `irq_n` is 0 exactly while some flag is set whose enable bit is 1.
- R8: The two alarms are independent: settings of one neither set nor clear the other's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per new second of live time |
| now_sec | input | 7 | Live seconds, BCD |
| now_min | input | 7 | Live minutes, BCD |
| now_hour | input | 6 | Live hour, BCD, bit 5 tens or PM |
| now_date | input | 6 | Live date, BCD |
| now_month | input | 5 | Live month, BCD |
| now_year | input | 8 | Live year, BCD |
| now_dow | input | 3 | Live day of week, 0 to 6 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The hardest case to reach is a flag being set and cleared in the same cycle. It needs a tick, a still-matching alarm and a status write that lands on the same clock edge. The stimulus drives `tick` and the clearing write together in one cycle, once with the alarm still matching and once after the day of week has moved away. The flag register then shows that the set wins and that a lone clear takes effect. The weekly case is reached by ticking twice with only the day of week changed, so a single field decides between match and no match.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int SLOT_W = 3;
    localparam int SLOTS  = 1 << SLOT_W;

    localparam logic [SLOT_W-1:0] SLOT_SEC   = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_MIN   = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_HOUR  = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_DATE  = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_MONTH = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_YEAR  = 3'd5;
    localparam logic [SLOT_W-1:0] SLOT_DOW   = 3'd6;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
        logic [2:0] dow;
    } clock_t;

    typedef struct packed {
        logic       en;
        logic [6:0] val;
    } field_t;

    function automatic logic [6:0] value_mask(logic [SLOT_W-1:0] s);
        case (s)
            SLOT_SEC, SLOT_MIN:    return 7'h7F;
            SLOT_HOUR, SLOT_DATE:  return 7'h3F;
            SLOT_MONTH:            return 7'h1F;
            SLOT_DOW:              return 7'h07;
            default:               return 7'h00;
        endcase
    endfunction

    function automatic logic slot_compared(logic [SLOT_W-1:0] s);
        return value_mask(s) != 7'h00;
    endfunction

    function automatic logic [6:0] live_value(clock_t t, logic [SLOT_W-1:0] s);
        case (s)
            SLOT_SEC:   return t.sec;
            SLOT_MIN:   return t.min;
            SLOT_HOUR:  return {1'b0, t.hour};
            SLOT_DATE:  return {1'b0, t.date};
            SLOT_MONTH: return {2'b00, t.month};
            SLOT_DOW:   return {4'b0000, t.dow};
            default:    return 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/cal_alarm_bank.sv
module cal_alarm_bank
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [7:0]        wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  clock_t            live,
    output logic [7:0]        rd_byte,
    output logic              match,
    output logic              any_en
);

    logic [SLOTS-1:0][7:0] slot_byte;
    logic [SLOTS-1:0]      slot_en;
    logic [SLOTS-1:0]      slot_hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [SLOT_W-1:0] S = SLOT_W'(g);
        if (slot_compared(S)) begin : g_field
            field_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_en && wr_slot == S)
                    q <= '{en: wr_data[7], val: wr_data[6:0] & value_mask(S)};
            end
            assign slot_byte[g] = q;
            assign slot_en[g]   = q.en;
            assign slot_hit[g]  = !q.en || (q.val == live_value(live, S));
        end else if (S == SLOT_YEAR) begin : g_year
            assign slot_byte[g] = live.year;
            assign slot_en[g]   = 1'b0;
            assign slot_hit[g]  = 1'b1;
        end else begin : g_spare
            assign slot_byte[g] = 8'h00;
            assign slot_en[g]   = 1'b0;
            assign slot_hit[g]  = 1'b1;
        end
    end

    assign rd_byte = slot_byte[rd_slot];
    assign any_en  = |slot_en;
    assign match   = any_en && (&slot_hit);

endmodule

// File: rtl/cal_alarm_flags.sv
module cal_alarm_flags #(
    parameter int NUM_ALARMS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [NUM_ALARMS-1:0] match,
    input  logic                  status_wr,
    input  logic                  ie_wr,
    input  logic [NUM_ALARMS-1:0] wr_bits,
    output logic [NUM_ALARMS-1:0] flags,
    output logic [NUM_ALARMS-1:0] ie,
    output logic                  irq_n
);

    logic [NUM_ALARMS-1:0] clear_mask;
    logic [NUM_ALARMS-1:0] set_mask;

    assign clear_mask = status_wr ? ~wr_bits : '0;
    assign set_mask   = tick ? match : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            ie    <= '0;
        end else begin
            flags <= (flags & ~clear_mask) | set_mask;
            if (ie_wr)
                ie <= wr_bits;
        end
    end

    assign irq_n = ~|(flags & ie);

endmodule

// File: rtl/cal_alarm_pair.sv
module cal_alarm_pair
    import cal_alarm_pkg::*;
#(
    parameter int NUM_ALARMS = 2,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [6:0]        now_sec,
    input  logic [6:0]        now_min,
    input  logic [5:0]        now_hour,
    input  logic [5:0]        now_date,
    input  logic [4:0]        now_month,
    input  logic [7:0]        now_year,
    input  logic [2:0]        now_dow,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_n
);

    localparam int BANK_W      = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;
    localparam int STATUS_ADDR = NUM_ALARMS * SLOTS;
    localparam int IE_ADDR     = STATUS_ADDR + 1;

    clock_t live;
    assign live = '{sec: now_sec, min: now_min, hour: now_hour, date: now_date,
                    month: now_month, year: now_year, dow: now_dow};

    logic                        in_banks;
    logic [BANK_W-1:0]           bank_sel;
    logic [SLOT_W-1:0]           slot_sel;
    logic                        status_hit;
    logic                        ie_hit;
    logic [NUM_ALARMS-1:0][7:0]  bank_byte;
    logic [NUM_ALARMS-1:0]       hit;
    logic [NUM_ALARMS-1:0]       en_any;
    logic [NUM_ALARMS-1:0]       flags;
    logic [NUM_ALARMS-1:0]       ie_q;

    assign in_banks   = bus_addr < ADDR_W'(STATUS_ADDR);
    assign bank_sel   = bus_addr[SLOT_W +: BANK_W];
    assign slot_sel   = bus_addr[SLOT_W-1:0];
    assign status_hit = bus_addr == ADDR_W'(STATUS_ADDR);
    assign ie_hit     = bus_addr == ADDR_W'(IE_ADDR);

    for (genvar b = 0; b < NUM_ALARMS; b++) begin : g_bank
        cal_alarm_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_wr && in_banks && bank_sel == BANK_W'(b)),
            .wr_slot (slot_sel),
            .wr_data (bus_wdata),
            .rd_slot (slot_sel),
            .live    (live),
            .rd_byte (bank_byte[b]),
            .match   (hit[b]),
            .any_en  (en_any[b])
        );
    end

    cal_alarm_flags #(.NUM_ALARMS(NUM_ALARMS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .match     (hit),
        .status_wr (bus_wr && status_hit),
        .ie_wr     (bus_wr && ie_hit),
        .wr_bits   (bus_wdata[NUM_ALARMS-1:0]),
        .flags     (flags),
        .ie        (ie_q),
        .irq_n     (irq_n)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (in_banks)
            bus_rdata = bank_byte[bank_sel];
        else if (status_hit)
            bus_rdata = 8'(flags);
        else if (ie_hit)
            bus_rdata = 8'(ie_q);
    end

endmodule

// File: rtl/cal_alarm_pair_chk.sv
module cal_alarm_pair_chk #(
    parameter int NUM_ALARMS = 2,
    parameter int ADDR_W     = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [7:0]            bus_wdata,
    input logic [NUM_ALARMS-1:0] hit,
    input logic [NUM_ALARMS-1:0] en_any,
    input logic [NUM_ALARMS-1:0] flags,
    input logic [NUM_ALARMS-1:0] ie_q,
    input logic                  irq_n
);

    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(NUM_ALARMS * 8);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (flags == '0 && ie_q == '0 && irq_n));

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_al
        assert_flag_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[a]) |-> ($past(tick) && $past(hit[a])));

        assert_no_enables_no_hit_R4: assert property (@(posedge clk) disable iff (rst)
            !en_any[a] |-> !hit[a]);

        assert_clear_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
            $fell(flags[a]) |-> $past(bus_wr && bus_addr == ST_ADDR && !bus_wdata[a]));
    end

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (|(flags & ie_q)));

endmodule

bind cal_alarm_pair cal_alarm_pair_chk #(.NUM_ALARMS(NUM_ALARMS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hit       (hit),
    .en_any    (en_any),
    .flags     (flags),
    .ie_q      (ie_q),
    .irq_n     (irq_n)
);

// File: tb/cal_alarm_pair_bench.sv
module cal_alarm_pair_bench;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0;
    logic [5:0] now_hour = '0, now_date = '0;
    logic [4:0] now_month = '0;
    logic [7:0] now_year = '0;
    logic [2:0] now_dow = '0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_alarm_pair u_cal_alarm_pair (
        .clk(clk), .rst(rst), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .now_month(now_month), .now_year(now_year),
        .now_dow(now_dow), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // Monitor: compares the oldest expected item against the outputs
    always @(posedge clk) begin
        if (q.size() != 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = (it.kind == 0) ? bus_rdata : {7'b0, irq_n};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        q.push_back('{kind: 0, exp: e, tag: tag});
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        q.push_back('{kind: 1, exp: {7'b0, e}, tag: tag});
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic tick_with_clear(input logic [7:0] d);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = d;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd(5'h00, 8'h00, "R1 alarm0 sec");
        rd(5'h02, 8'h00, "R1 alarm0 hour");
        rd(5'h0E, 8'h00, "R1 alarm1 dow");
        rd(5'h10, 8'h00, "R1 flags");
        rd(5'h11, 8'h00, "R1 irq enable");
        chk_irq(1'b1, "R1 irq idle");

        now_sec = 7'h05; now_min = 7'h30; now_hour = 6'h21;
        now_date = 6'h15; now_month = 5'h06; now_year = 8'h24; now_dow = 3'd2;

        // R2: reserved bits dropped
        wr(5'h04, 8'hFF); rd(5'h04, 8'h9F, "R2 month mask");
        wr(5'h0E, 8'hFF); rd(5'h0E, 8'h87, "R2 dow mask");
        wr(5'h02, 8'hFF); rd(5'h02, 8'hBF, "R2 hour mask");
        wr(5'h0B, 8'hFF); rd(5'h0B, 8'hBF, "R2 date mask");
        wr(5'h08, 8'hFF); rd(5'h08, 8'hFF, "R2 sec full");

        // R5: year slot and spare slot
        wr(5'h05, 8'h55); rd(5'h05, 8'h24, "R5 year reads live");
        rd(5'h0D, 8'h24, "R5 alarm1 year");
        wr(5'h07, 8'hFF); rd(5'h07, 8'h00, "R5 spare slot");

        wr(5'h04, 8'h00); wr(5'h0E, 8'h00); wr(5'h02, 8'h00);
        wr(5'h0B, 8'h00); wr(5'h08, 8'h00);

        // R3: daily alarm 21:30, no tick then tick
        wr(5'h02, 8'hA1); wr(5'h01, 8'hB0);
        repeat (3) @(negedge clk);
        rd(5'h10, 8'h00, "R3 no tick no flag");
        pulse_tick();
        rd(5'h10, 8'h01, "R3 match on tick");

        // R4: alarm1 values equal live but no enables
        wr(5'h08, 8'h05); wr(5'h09, 8'h30); wr(5'h0A, 8'h21);
        wr(5'h0B, 8'h15); wr(5'h0C, 8'h06); wr(5'h0E, 8'h02);
        pulse_tick();
        rd(5'h10, 8'h01, "R4 disabled alarm silent");

        // R6: write 1 keeps, write 0 clears
        wr(5'h10, 8'h03); rd(5'h10, 8'h01, "R6 write one keeps");
        wr(5'h10, 8'h00); rd(5'h10, 8'h00, "R6 write zero clears");

        // R3: minute mismatch
        now_min = 7'h31;
        pulse_tick();
        rd(5'h10, 8'h00, "R3 mismatch no flag");

        // R5: year not compared
        now_min = 7'h30; now_year = 8'h99;
        pulse_tick();
        rd(5'h10, 8'h01, "R5 year ignored in match");
        wr(5'h10, 8'h00);

        // R8: weekly alarm1 Wed 08:00 (dow 3)
        wr(5'h0E, 8'h83); wr(5'h0A, 8'h88); wr(5'h09, 8'h80);
        now_hour = 6'h08; now_min = 7'h00; now_dow = 3'd2;
        pulse_tick();
        rd(5'h10, 8'h00, "R8 wrong weekday");
        now_dow = 3'd3;
        pulse_tick();
        rd(5'h10, 8'h02, "R8 alarm1 alone");

        // R7: interrupt gating
        chk_irq(1'b1, "R7 masked");
        wr(5'h11, 8'h02); chk_irq(1'b0, "R7 enabled flag");
        rd(5'h11, 8'h02, "R7 ie readback");
        wr(5'h11, 8'h01); chk_irq(1'b1, "R7 other enable");
        wr(5'h11, 8'hFF); rd(5'h11, 8'h03, "R7 ie reserved");
        chk_irq(1'b0, "R7 both enabled");

        // R6: set and clear in the same cycle
        tick_with_clear(8'h00);
        rd(5'h10, 8'h02, "R6 set beats clear");
        now_dow = 3'd4;
        tick_with_clear(8'h00);
        rd(5'h10, 8'h00, "R6 clear without match");
        chk_irq(1'b1, "R7 idle after clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule